// File: doc/BRIEF.md
# Two-Lane Serial I/Q Sample Deserializer

This block turns bit-serial baseband samples arriving on two data pins into parallel signed I and Q words for an upconversion datapath. Both pins share one bit clock, one bit-enable qualifier and one frame strobe. A mode input picks the pin mapping. In two-channel mode each pin carries its own channel: the I word comes first and the Q word follows it on the same pin. In one-channel mode pin A carries I and pin B carries Q during the same bit times, and the pair comes out on channel A.

The serial word length can be set from 1 to 32 bits. Only the leading 18 bits of a word can become sample data. A second setting, the sample width, keeps only the leading 1 to 18 of those bits. Recovered words are left-justified in an 18-bit field, and the bits below them are zero.

Each output channel is a valid/ready stream. The serial side cannot be stalled, so back-pressure never slows the pins. While a sample waits unaccepted, valid and the data stay steady until ready is seen high. If a newer sample completes before that, it replaces the waiting one.

Top module: `serial_iq_deser`

## Requirements
- R1: After reset, neither output channel presents valid data.
- R2: With `two_ch_mode` = 1, pin A carries channel A and pin B carries channel B, and the two are assembled independently. On each pin the frame is the I word followed directly by the Q word, each `word_len_m1`+1 bits long.
- R3: Each word arrives MSB first. One bit is taken per clock cycle in which `bit_en` is 1. Cycles with `bit_en` = 0 are ignored entirely, including the data pins and `frame_sync`.
- R4: The serial word length is `word_len_m1`+1, from 1 to 32 bits. Word bits after the 18th are discarded.
- R5: `samp_width` (1 to 18) sets how many leading word bits are kept. Received bit k, counted from 0 at the MSB, lands at output bit 17-k when k < `samp_width` and k < word length. Every other output bit is 0.
- R6: With `two_ch_mode` = 0, pin A's word becomes I and pin B's simultaneous word becomes Q, both delivered on channel A. Channel B's valid never rises in this mode.
- R7: `frame_sync` marks the MSB bit of a frame and is sampled with it. A strobe before the current frame has completed drops the partial frame, and that bit starts a new frame.
- R8: After a frame completes, bits that arrive without a strobe are ignored and produce no output.
- R9: A completed sample sets the channel's valid at the clock edge after the edge that took the final bit. While ready is 0, valid and the data hold, except that a newly completed sample overwrites them.
- R10: Valid clears at an edge where ready is 1 and no new sample is being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| two_ch_mode | input | 1 | 1 = two independent channels, 0 = one channel with I on pin A and Q on pin B |
| word_len_m1 | input | 5 | Serial word length minus one |
| samp_width | input | 5 | Number of leading word bits kept, 1 to 18 |
| bit_en | input | 1 | Qualifies the pins for this cycle |
| frame_sync | input | 1 | Frame start strobe, aligned with the MSB bit |
| sdi_a | input | 1 | Serial data pin A |
| sdi_b | input | 1 | Serial data pin B |
| a_valid | output | 1 | Channel A sample available |
| a_ready | input | 1 | Channel A consumer accepts |
| a_i | output | 18 | Channel A I word, left-justified |
| a_q | output | 18 | Channel A Q word, left-justified |
| b_valid | output | 1 | Channel B sample available |
| b_ready | input | 1 | Channel B consumer accepts |
| b_i | output | 18 | Channel B I word, left-justified |
| b_q | output | 18 | Channel B Q word, left-justified |

## Verification
The hardest case to reach from the ports is a frame strobe that lands partway through a frame. The partial word must be dropped, including any I word it had already finished, and the strobed bit must start the next frame. The bench reaches this by sending a truncated frame with its own strobe, then a full frame strobed while the first is still incomplete. It then checks that exactly one sample comes out and that it carries the second frame's data. The interaction of word length with sample width is covered by sweeping every length from 1 to 32 against every width from 1 to 18 in two-channel mode. Disabled cycles carrying a strobe are inserted within frames throughout the sweep.

// File: rtl/iqdes_pkg.sv
package iqdes_pkg;
  localparam int unsigned SAMP_W  = 18;
  localparam int unsigned LEN_MAX = 32;
  localparam int unsigned LEN_W   = $clog2(LEN_MAX);
  localparam int unsigned SWID_W  = $clog2(SAMP_W + 1);
  localparam int unsigned N_LANES = 2;
endpackage

// File: rtl/iqdes_lane.sv
module iqdes_lane #(
  parameter int unsigned SW  = 18,
  parameter int unsigned LW  = 5,
  parameter int unsigned WW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          sdi,
  input  logic          sync,
  input  logic [LW-1:0] len_m1,
  input  logic [WW-1:0] width,
  input  logic          two_words,
  output logic          done,
  output logic [SW-1:0] word0,
  output logic [SW-1:0] word1
);
  logic [LW-1:0] cnt, pos;
  logic          widx, wsel, active, take, last_bit, last_word;
  logic [SW-1:0] nxt0, nxt1;

  always_comb begin
    take = bit_en & (sync | active);
    pos  = sync ? '0 : cnt;
    wsel = sync ? 1'b0 : widx;
    nxt0 = sync ? '0 : word0;
    nxt1 = sync ? '0 : word1;
    if ((int'(pos) < int'(width)) && (int'(pos) < int'(SW))) begin
      if (wsel) nxt1[SW-1-int'(pos)] = sdi;
      else      nxt0[SW-1-int'(pos)] = sdi;
    end
    last_bit  = (pos == len_m1);
    last_word = (wsel == two_words);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; widx <= 1'b0; active <= 1'b0; done <= 1'b0;
      word0 <= '0; word1 <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        word0 <= nxt0;
        word1 <= nxt1;
        if (last_bit) begin
          cnt <= '0;
          if (last_word) begin
            widx <= 1'b0; active <= 1'b0; done <= 1'b1;
          end else begin
            widx <= 1'b1; active <= 1'b1;
          end
        end else begin
          cnt <= pos + 1'b1; widx <= wsel; active <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iqdes_hold.sv
module iqdes_hold #(
  parameter int unsigned SW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] in_i,
  input  logic [SW-1:0] in_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_i,
  output logic [SW-1:0] out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_i <= '0; out_q <= '0;
    end else if (load) begin
      out_valid <= 1'b1; out_i <= in_i; out_q <= in_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_iq_deser.sv
module serial_iq_deser
  import iqdes_pkg::*;
#(
  parameter int unsigned SW = SAMP_W,
  parameter int unsigned LW = LEN_W,
  parameter int unsigned WW = SWID_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_ch_mode,
  input  logic [LW-1:0] word_len_m1,
  input  logic [WW-1:0] samp_width,
  input  logic          bit_en,
  input  logic          frame_sync,
  input  logic          sdi_a,
  input  logic          sdi_b,
  output logic          a_valid,
  input  logic          a_ready,
  output logic [SW-1:0] a_i,
  output logic [SW-1:0] a_q,
  output logic          b_valid,
  input  logic          b_ready,
  output logic [SW-1:0] b_i,
  output logic [SW-1:0] b_q
);
  logic [N_LANES-1:0] pin_bits, lane_done;
  logic [SW-1:0]      lane_w0 [N_LANES];
  logic [SW-1:0]      lane_w1 [N_LANES];
  logic               load_a, load_b;
  logic [SW-1:0]      a_q_src;

  assign pin_bits = {sdi_b, sdi_a};

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    iqdes_lane #(.SW(SW), .LW(LW), .WW(WW)) u_lane (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdi(pin_bits[g]),
      .sync(frame_sync), .len_m1(word_len_m1), .width(samp_width),
      .two_words(two_ch_mode), .done(lane_done[g]),
      .word0(lane_w0[g]), .word1(lane_w1[g])
    );
  end

  // one-channel mode: both lanes run in lockstep, lane 1 supplies Q
  assign load_a  = lane_done[0];
  assign load_b  = lane_done[1] & two_ch_mode;
  assign a_q_src = two_ch_mode ? lane_w1[0] : lane_w0[1];

  iqdes_hold #(.SW(SW)) u_hold_a (
    .clk(clk), .rst_n(rst_n), .load(load_a), .in_i(lane_w0[0]), .in_q(a_q_src),
    .out_valid(a_valid), .out_ready(a_ready), .out_i(a_i), .out_q(a_q)
  );

  iqdes_hold #(.SW(SW)) u_hold_b (
    .clk(clk), .rst_n(rst_n), .load(load_b), .in_i(lane_w0[1]), .in_q(lane_w1[1]),
    .out_valid(b_valid), .out_ready(b_ready), .out_i(b_i), .out_q(b_q)
  );
endmodule

// File: rtl/iqdes_chk.sv
module iqdes_chk #(
  parameter int unsigned SW = 18,
  parameter int unsigned WW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          two_ch_mode,
  input logic          bit_en,
  input logic [WW-1:0] samp_width,
  input logic [1:0]    lane_done,
  input logic          a_valid,
  input logic          a_ready,
  input logic [SW-1:0] a_i,
  input logic [SW-1:0] a_q,
  input logic          b_valid,
  input logic [SW-1:0] b_i,
  input logic [SW-1:0] b_q
);
  logic [SW-1:0] low_mask;
  assign low_mask = {SW{1'b1}} >> samp_width;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_valid) |-> $past(lane_done[0]));
  a_r3_done_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_done != 2'b00) |-> $past(bit_en));
  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (((a_i | a_q) & low_mask) == '0));
  a_r5_low_bits_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (((b_i | b_q) & low_mask) == '0));
  a_r6_b_quiet_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(two_ch_mode));
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_ready && !lane_done[0]) |=> (a_valid && $stable(a_i) && $stable(a_q)));
  a_r10_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && !lane_done[0]) |=> !a_valid);
endmodule

bind serial_iq_deser iqdes_chk #(.SW(SW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .two_ch_mode(two_ch_mode), .bit_en(bit_en),
  .samp_width(samp_width), .lane_done(lane_done),
  .a_valid(a_valid), .a_ready(a_ready), .a_i(a_i), .a_q(a_q),
  .b_valid(b_valid), .b_i(b_i), .b_q(b_q)
);

// File: tb/serial_iq_deser_tb.sv
module serial_iq_deser_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic two_ch_mode = 1'b1, bit_en = 1'b0, frame_sync = 1'b0, sdi_a = 1'b0, sdi_b = 1'b0;
  logic [4:0] word_len_m1 = 5'd7, samp_width = 5'd18;
  logic a_ready = 1'b1, b_ready = 1'b1;
  logic a_valid, b_valid;
  logic [17:0] a_i, a_q, b_i, b_q;
  int checks = 0, errors = 0, a_cnt = 0, b_cnt = 0;
  logic [17:0] a_gi, a_gq, b_gi, b_gq;
  bit done_flag = 0;

  always #2 clk = ~clk;

  serial_iq_deser u_dut (
    .clk(clk), .rst_n(rst_n), .two_ch_mode(two_ch_mode), .word_len_m1(word_len_m1),
    .samp_width(samp_width), .bit_en(bit_en), .frame_sync(frame_sync),
    .sdi_a(sdi_a), .sdi_b(sdi_b), .a_valid(a_valid), .a_ready(a_ready),
    .a_i(a_i), .a_q(a_q), .b_valid(b_valid), .b_ready(b_ready), .b_i(b_i), .b_q(b_q)
  );

  // handshake monitor: sees the same pre-edge values the design sees
  always @(posedge clk) if (rst_n) begin
    if (a_valid && a_ready) begin a_cnt <= a_cnt + 1; a_gi <= a_i; a_gq <= a_q; end
    if (b_valid && b_ready) begin b_cnt <= b_cnt + 1; b_gi <= b_i; b_gq <= b_q; end
  end

  function automatic logic [31:0] pat(int s);
    return (32'(s) * 32'h9E3779B1) ^ (32'(s) << 7) ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [17:0] expw(logic [31:0] p, int len, int wid);
    logic [17:0] r = '0;
    for (int k = 0; k < 18; k++)
      if (k < len && k < wid) r[17-k] = p[31-k];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1'b0; frame_sync = 1'b0; sdi_a = 1'b0; sdi_b = 1'b0;
    end
  endtask

  // nbits bits per pin; pin A sends p0 then p1, pin B p2 then p3 (two words)
  // or pin A p0, pin B p1 (one word). Optional disabled cycle with junk.
  task automatic send(int len, int words, int nbits, bit strobe,
                      logic [31:0] p0, logic [31:0] p1, logic [31:0] p2, logic [31:0] p3,
                      bit gap);
    for (int n = 0; n < nbits; n++) begin
      int w = n / len;
      int b = n % len;
      if (gap && n == 1) begin
        @(negedge clk); bit_en = 1'b0; frame_sync = 1'b1; sdi_a = ~sdi_a; sdi_b = ~sdi_b;
      end
      @(negedge clk);
      bit_en = 1'b1;
      frame_sync = strobe && (n == 0);
      if (words == 2) begin
        sdi_a = w ? p1[31-b] : p0[31-b];
        sdi_b = w ? p3[31-b] : p2[31-b];
      end else begin
        sdi_a = p0[31-b];
        sdi_b = p1[31-b];
      end
    end
  endtask

  initial begin
    #640_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    int ca, cb, seed;
    logic [31:0] q0, q1, q2, q3;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(!a_valid && !b_valid, "R1 reset valids", {34'd0, a_valid, b_valid}, 36'd0);

    // R2 R3 R4 R5: two-channel sweep of every length against every width
    seed = 1;
    two_ch_mode = 1'b1;
    for (int len = 1; len <= 32; len++) begin
      for (int wid = 1; wid <= 18; wid++) begin
        word_len_m1 = 5'(len - 1); samp_width = 5'(wid);
        q0 = pat(seed); q1 = pat(seed + 1); q2 = pat(seed + 2); q3 = pat(seed + 3);
        seed += 4;
        ca = a_cnt; cb = b_cnt;
        send(len, 2, 2 * len, 1'b1, q0, q1, q2, q3, (wid % 3) == 0);
        idle(3);
        chk(a_cnt == ca + 1 && b_cnt == cb + 1, "R2 one sample per channel",
            36'(a_cnt - ca) << 18 | 36'(b_cnt - cb), 36'h40001);
        chk({a_gi, a_gq} == {expw(q0, len, wid), expw(q1, len, wid)}, "R2 R4 R5 channel A",
            {a_gi, a_gq}, {expw(q0, len, wid), expw(q1, len, wid)});
        chk({b_gi, b_gq} == {expw(q2, len, wid), expw(q3, len, wid)}, "R2 R3 R5 channel B",
            {b_gi, b_gq}, {expw(q2, len, wid), expw(q3, len, wid)});
      end
    end

    // R6: one-channel mode, I on pin A and Q on pin B
    two_ch_mode = 1'b0;
    idle(2);
    for (int len = 1; len <= 32; len += 3) begin
      for (int wid = 4; wid <= 18; wid += 7) begin
        word_len_m1 = 5'(len - 1); samp_width = 5'(wid);
        q0 = pat(seed); q1 = pat(seed + 1); seed += 2;
        ca = a_cnt; cb = b_cnt;
        send(len, 1, len, 1'b1, q0, q1, 32'd0, 32'd0, len > 4);
        idle(3);
        chk(a_cnt == ca + 1, "R6 single sample on A", 36'(a_cnt - ca), 36'd1);
        chk({a_gi, a_gq} == {expw(q0, len, wid), expw(q1, len, wid)}, "R6 single I/Q",
            {a_gi, a_gq}, {expw(q0, len, wid), expw(q1, len, wid)});
        chk(b_cnt == cb && !b_valid, "R6 channel B quiet", 36'(b_cnt - cb), 36'd0);
      end
    end

    // R7: strobe mid-frame restarts, partial frame (with a complete I word) dropped
    two_ch_mode = 1'b1; word_len_m1 = 5'd9; samp_width = 5'd18;
    idle(2);
    ca = a_cnt;
    send(10, 2, 13, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    q0 = pat(901); q1 = pat(902); q2 = pat(903); q3 = pat(904);
    send(10, 2, 20, 1'b1, q0, q1, q2, q3, 1'b0);
    idle(3);
    chk(a_cnt == ca + 1, "R7 only restarted frame delivered", 36'(a_cnt - ca), 36'd1);
    chk({a_gi, a_gq} == {expw(q0, 10, 18), expw(q1, 10, 18)}, "R7 restarted data",
        {a_gi, a_gq}, {expw(q0, 10, 18), expw(q1, 10, 18)});

    // R8: unstrobed bits after a completed frame are ignored
    ca = a_cnt; cb = b_cnt;
    send(10, 2, 20, 1'b0, pat(7), pat(8), pat(9), pat(10), 1'b0);
    idle(3);
    chk(a_cnt == ca && b_cnt == cb && !a_valid, "R8 no output without strobe",
        36'(a_cnt - ca + b_cnt - cb), 36'd0);

    // R9 R10: back-pressure hold, overwrite, then release
    a_ready = 1'b0;
    ca = a_cnt;
    q0 = pat(501); q1 = pat(502);
    send(10, 2, 20, 1'b1, q0, q1, pat(503), pat(504), 1'b0);
    idle(3);
    chk(a_valid && {a_i, a_q} == {expw(q0, 10, 18), expw(q1, 10, 18)}, "R9 held sample",
        {a_i, a_q}, {expw(q0, 10, 18), expw(q1, 10, 18)});
    idle(6);
    chk(a_valid && {a_i, a_q} == {expw(q0, 10, 18), expw(q1, 10, 18)}, "R9 still held",
        {a_i, a_q}, {expw(q0, 10, 18), expw(q1, 10, 18)});
    q0 = pat(601); q1 = pat(602);
    send(10, 2, 20, 1'b1, q0, q1, pat(603), pat(604), 1'b0);
    @(negedge clk); bit_en = 1'b0; frame_sync = 1'b0;
    chk(a_valid && {a_i, a_q} != {expw(q0, 10, 18), expw(q1, 10, 18)}, "R9 load one edge late",
        {a_i, a_q}, {expw(pat(501), 10, 18), expw(pat(502), 10, 18)});
    @(negedge clk);
    chk(a_valid && {a_i, a_q} == {expw(q0, 10, 18), expw(q1, 10, 18)}, "R9 overwrite",
        {a_i, a_q}, {expw(q0, 10, 18), expw(q1, 10, 18)});
    chk(a_cnt == ca, "R9 nothing taken while not ready", 36'(a_cnt - ca), 36'd0);
    a_ready = 1'b1;
    @(negedge clk);
    chk(!a_valid && a_cnt == ca + 1, "R10 valid clears on take", {35'd0, a_valid}, 36'd0);
    chk({a_gi, a_gq} == {expw(q0, 10, 18), expw(q1, 10, 18)}, "R10 taken data",
        {a_gi, a_gq}, {expw(q0, 10, 18), expw(q1, 10, 18)});

    idle(2);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule